// File: doc/BRIEF.md
# Interrupt Level Register Bank Controller

This block keeps several complete copies of a small processor context (accumulator, program counter and link/carry bit) and chooses which copy is live. One copy belongs to the normal running level, called the base level. Each interrupt request input has its own copy. Taking an interrupt or returning from one changes only the bank selector, so no context moves to or from memory and neither entry nor exit costs a save or restore cycle.

Each request input has an enable bit that software writes. An enabled, pending request takes effect only at an instruction boundary, and only while the base level is running. A return strobe selects the base level again. The datapath reads and writes the accumulator, program counter and link through a single set of ports, and these always reach the active bank. The base level also holds an auxiliary flag bit, which none of the interrupt levels has.

Top module: `ctx_bank_top`

## Requirements
- R1: After reset, level_o is 3 (the base level), both enables are cleared, and every bank reads back as zero, including the auxiliary bit.
- R2: level_o leaves the base level only in the cycle after a cycle with boundary_i high. While boundary_i stays low, a pending enabled request leaves level_o at 3.
- R3: A request whose enable is clear never changes level_o, even at a boundary.
- R4: Request input bit 0 selects level 1 and bit 1 selects level 2. If both are pending and enabled at the same boundary, level 1 is taken.
- R5: While level_o is 1 or 2, further requests and boundaries leave level_o unchanged until a return, so interrupts do not nest.
- R6: rti_i high makes level_o equal 3 from the next cycle. At the base level it has no effect on the level or on any bank.
- R7: acc_o, pc_o and link_o show the active bank, and writes go only to the active bank. The other banks keep their contents across level changes.
- R8: Only the base level has the auxiliary bit. aux_o always shows it, and aux_we_i writes it whatever level is active.
- R9: en_we_i loads en_wdata_i, with bit 0 enabling request 0 and bit 1 enabling request 1. A boundary in the same cycle as the write still uses the old enables.
- R10: When rti_i and boundary_i are high in the same cycle, the return wins and level_o is 3 in the next cycle, even if enabled requests are pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| irq_i | input | 2 | Interrupt requests, level sensitive; bit 0 selects level 1, bit 1 selects level 2 |
| en_we_i | input | 1 | Write strobe for the enables |
| en_wdata_i | input | 2 | New enable values, one bit per request |
| boundary_i | input | 1 | Current instruction completes this cycle |
| rti_i | input | 1 | Return-from-interrupt strobe |
| acc_we_i | input | 1 | Accumulator write strobe |
| acc_wdata_i | input | 8 | Accumulator write data |
| pc_we_i | input | 1 | Program counter write strobe |
| pc_wdata_i | input | 16 | Program counter write data |
| link_we_i | input | 1 | Link write strobe |
| link_wdata_i | input | 1 | Link write data |
| aux_we_i | input | 1 | Auxiliary bit write strobe |
| aux_wdata_i | input | 1 | Auxiliary bit write data |
| level_o | output | 2 | Active level: 1, 2 or 3 (base) |
| acc_o | output | 8 | Accumulator of the active bank |
| pc_o | output | 16 | Program counter of the active bank |
| link_o | output | 1 | Link bit of the active bank |
| aux_o | output | 1 | Auxiliary bit of the base bank |

## Verification
The bench uses the default parameters: two request inputs, which give three levels, an 8-bit accumulator and a 16-bit program counter. With these values every level can be reached, and both the single-request case and the simultaneous-request priority case can be driven. Each bank is filled with distinct values, so a write that leaks into another bank, or a read from the wrong bank, shows up when control returns to an earlier level. The enable-write and return strobes are also driven in the same cycle as a boundary.

// File: rtl/ctx_bank_pkg.sv
package ctx_bank_pkg;
  localparam int unsigned DEF_NUM_IRQ = 2;
  localparam int unsigned DEF_ACC_W   = 8;
  localparam int unsigned DEF_PC_W    = 16;

  function automatic int unsigned lvl_width(input int unsigned num_irq);
    return $clog2(num_irq + 2);
  endfunction
endpackage

// File: rtl/ctx_level_ctrl.sv
module ctx_level_ctrl #(
  parameter int unsigned NUM_IRQ = ctx_bank_pkg::DEF_NUM_IRQ,
  localparam int unsigned LVL_W  = ctx_bank_pkg::lvl_width(NUM_IRQ)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_IRQ-1:0] irq_i,
  input  logic               en_we_i,
  input  logic [NUM_IRQ-1:0] en_wdata_i,
  input  logic               boundary_i,
  input  logic               rti_i,
  output logic [LVL_W-1:0]   level_o
);
  localparam logic [LVL_W-1:0] BASE = LVL_W'(NUM_IRQ + 1);

  logic [NUM_IRQ-1:0] en_q;
  logic [NUM_IRQ-1:0] pend;
  logic [LVL_W-1:0]   lvl_q, lvl_d, sel;

  assign pend = irq_i & en_q;

  // lowest index wins
  always_comb begin
    sel = BASE;
    for (int k = NUM_IRQ - 1; k >= 0; k--) begin
      if (pend[k]) sel = LVL_W'(k + 1);
    end
  end

  always_comb begin
    lvl_d = lvl_q;
    if (rti_i) lvl_d = BASE;
    else if (boundary_i && lvl_q == BASE && |pend) lvl_d = sel;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lvl_q <= BASE;
      en_q  <= '0;
    end else begin
      lvl_q <= lvl_d;
      if (en_we_i) en_q <= en_wdata_i;
    end
  end

  assign level_o = lvl_q;

  a_r1_level_legal: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lvl_q != '0) && (lvl_q <= BASE));
  a_r2_entry_at_boundary: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lvl_q == BASE && !boundary_i) |=> (lvl_q == BASE));
  a_r3_disabled_no_entry: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lvl_q == BASE && (irq_i & en_q) == '0) |=> (lvl_q == BASE));
  a_r4_int1_first: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lvl_q == BASE && boundary_i && !rti_i && irq_i[0] && en_q[0]) |=> (lvl_q == LVL_W'(1)));
  a_r5_no_nest: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lvl_q != BASE && !rti_i) |=> $stable(lvl_q));
  a_r6_rti_base: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rti_i |=> (lvl_q == BASE));
endmodule

// File: rtl/ctx_bank_reg.sv
module ctx_bank_reg #(
  parameter int unsigned ACC_W   = ctx_bank_pkg::DEF_ACC_W,
  parameter int unsigned PC_W    = ctx_bank_pkg::DEF_PC_W,
  parameter bit          HAS_AUX = 1'b0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             acc_we_i,
  input  logic [ACC_W-1:0] acc_d_i,
  input  logic             pc_we_i,
  input  logic [PC_W-1:0]  pc_d_i,
  input  logic             link_we_i,
  input  logic             link_d_i,
  input  logic             aux_we_i,
  input  logic             aux_d_i,
  output logic [ACC_W-1:0] acc_o,
  output logic [PC_W-1:0]  pc_o,
  output logic             link_o,
  output logic             aux_o
);
  logic [ACC_W-1:0] acc_q;
  logic [PC_W-1:0]  pc_q;
  logic             link_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q  <= '0;
      pc_q   <= '0;
      link_q <= 1'b0;
    end else begin
      if (acc_we_i)  acc_q  <= acc_d_i;
      if (pc_we_i)   pc_q   <= pc_d_i;
      if (link_we_i) link_q <= link_d_i;
    end
  end

  generate
    if (HAS_AUX) begin : g_aux
      logic aux_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)       aux_q <= 1'b0;
        else if (aux_we_i) aux_q <= aux_d_i;
      end
      assign aux_o = aux_q;
    end else begin : g_no_aux
      logic unused_aux;
      assign unused_aux = aux_we_i ^ aux_d_i;
      assign aux_o = 1'b0;
    end
  endgenerate

  assign acc_o  = acc_q;
  assign pc_o   = pc_q;
  assign link_o = link_q;

  a_r7_acc_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !acc_we_i |=> $stable(acc_q));
  a_r7_pc_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pc_we_i |=> $stable(pc_q));
endmodule

// File: rtl/ctx_bank_top.sv
module ctx_bank_top #(
  parameter int unsigned NUM_IRQ = ctx_bank_pkg::DEF_NUM_IRQ,
  parameter int unsigned ACC_W   = ctx_bank_pkg::DEF_ACC_W,
  parameter int unsigned PC_W    = ctx_bank_pkg::DEF_PC_W,
  localparam int unsigned NUM_LVL = NUM_IRQ + 1,
  localparam int unsigned LVL_W   = ctx_bank_pkg::lvl_width(NUM_IRQ)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_IRQ-1:0] irq_i,
  input  logic               en_we_i,
  input  logic [NUM_IRQ-1:0] en_wdata_i,
  input  logic               boundary_i,
  input  logic               rti_i,
  input  logic               acc_we_i,
  input  logic [ACC_W-1:0]   acc_wdata_i,
  input  logic               pc_we_i,
  input  logic [PC_W-1:0]    pc_wdata_i,
  input  logic               link_we_i,
  input  logic               link_wdata_i,
  input  logic               aux_we_i,
  input  logic               aux_wdata_i,
  output logic [LVL_W-1:0]   level_o,
  output logic [ACC_W-1:0]   acc_o,
  output logic [PC_W-1:0]    pc_o,
  output logic               link_o,
  output logic               aux_o
);
  logic [LVL_W-1:0] level;
  logic [ACC_W-1:0] acc_b  [NUM_LVL];
  logic [PC_W-1:0]  pc_b   [NUM_LVL];
  logic             link_b [NUM_LVL];
  logic             aux_b  [NUM_LVL];

  ctx_level_ctrl #(.NUM_IRQ(NUM_IRQ)) u_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .irq_i      (irq_i),
    .en_we_i    (en_we_i),
    .en_wdata_i (en_wdata_i),
    .boundary_i (boundary_i),
    .rti_i      (rti_i),
    .level_o    (level)
  );

  for (genvar g = 0; g < NUM_LVL; g++) begin : g_bank
    localparam bit IS_BASE = (g == NUM_LVL - 1);
    logic act;
    assign act = (level == LVL_W'(g + 1));

    ctx_bank_reg #(.ACC_W(ACC_W), .PC_W(PC_W), .HAS_AUX(IS_BASE)) u_bank (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .acc_we_i  (acc_we_i & act),
      .acc_d_i   (acc_wdata_i),
      .pc_we_i   (pc_we_i & act),
      .pc_d_i    (pc_wdata_i),
      .link_we_i (link_we_i & act),
      .link_d_i  (link_wdata_i),
      .aux_we_i  (aux_we_i),
      .aux_d_i   (aux_wdata_i),
      .acc_o     (acc_b[g]),
      .pc_o      (pc_b[g]),
      .link_o    (link_b[g]),
      .aux_o     (aux_b[g])
    );
  end

  always_comb begin
    acc_o  = '0;
    pc_o   = '0;
    link_o = 1'b0;
    for (int k = 0; k < NUM_LVL; k++) begin
      if (level == LVL_W'(k + 1)) begin
        acc_o  = acc_b[k];
        pc_o   = pc_b[k];
        link_o = link_b[k];
      end
    end
  end

  assign aux_o   = aux_b[NUM_LVL-1];
  assign level_o = level;

  a_r8_aux_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    aux_we_i |=> (aux_o == $past(aux_wdata_i)));
  a_r7_acc_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_we_i && !rti_i && !boundary_i) |=> (acc_o == $past(acc_wdata_i)));
endmodule

// File: tb/tb_ctx_bank_top.sv
module tb_ctx_bank_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [1:0]  irq_i = '0;
  logic        en_we_i = 1'b0;
  logic [1:0]  en_wdata_i = '0;
  logic        boundary_i = 1'b0;
  logic        rti_i = 1'b0;
  logic        acc_we_i = 1'b0;
  logic [7:0]  acc_wdata_i = '0;
  logic        pc_we_i = 1'b0;
  logic [15:0] pc_wdata_i = '0;
  logic        link_we_i = 1'b0;
  logic        link_wdata_i = 1'b0;
  logic        aux_we_i = 1'b0;
  logic        aux_wdata_i = 1'b0;
  logic [1:0]  level_o;
  logic [7:0]  acc_o;
  logic [15:0] pc_o;
  logic        link_o;
  logic        aux_o;

  int checks = 0;
  int errors = 0;

  always #4 clk_i = ~clk_i;

  ctx_bank_top dut (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic tick;
    @(posedge clk_i);
    @(negedge clk_i);
  endtask

  task automatic idle;
    en_we_i = 0; boundary_i = 0; rti_i = 0;
    acc_we_i = 0; pc_we_i = 0; link_we_i = 0; aux_we_i = 0;
  endtask

  task automatic t_reset;
    chk("R1 level", level_o, 3);
    chk("R1 acc", acc_o, 0);
    chk("R1 pc", pc_o, 0);
    chk("R1 link", link_o, 0);
    chk("R1 aux", aux_o, 0);
    @(negedge clk_i); rst_ni = 1;
    tick;
  endtask

  task automatic t_base_write;
    acc_we_i = 1; acc_wdata_i = 8'h5A;
    pc_we_i = 1; pc_wdata_i = 16'h1234;
    link_we_i = 1; link_wdata_i = 1;
    aux_we_i = 1; aux_wdata_i = 1;
    tick; idle;
    chk("R7 base acc", acc_o, 8'h5A);
    chk("R7 base pc", pc_o, 16'h1234);
    chk("R7 base link", link_o, 1);
    chk("R8 base aux", aux_o, 1);
  endtask

  task automatic t_disabled;
    irq_i = 2'b11; boundary_i = 1;
    tick; idle;
    chk("R3 disabled stays base", level_o, 3);
    chk("R3 acc untouched", acc_o, 8'h5A);
  endtask

  task automatic t_enable_timing;
    irq_i = 2'b10; en_we_i = 1; en_wdata_i = 2'b10; boundary_i = 1;
    tick; idle;
    chk("R9 old enable at boundary", level_o, 3);
    tick;
    chk("R2 no boundary no switch", level_o, 3);
    boundary_i = 1;
    tick; idle;
    chk("R2 switch after boundary", level_o, 2);
  endtask

  task automatic t_bank;
    chk("R7 level2 acc fresh", acc_o, 0);
    chk("R7 level2 pc fresh", pc_o, 0);
    chk("R7 level2 link fresh", link_o, 0);
    chk("R8 aux seen at level2", aux_o, 1);
    acc_we_i = 1; acc_wdata_i = 8'h77;
    pc_we_i = 1; pc_wdata_i = 16'h0ABC;
    aux_we_i = 1; aux_wdata_i = 0;
    tick; idle;
    chk("R7 level2 acc", acc_o, 8'h77);
    chk("R7 level2 pc", pc_o, 16'h0ABC);
    chk("R8 aux written at level2", aux_o, 0);
  endtask

  task automatic t_no_nest;
    en_we_i = 1; en_wdata_i = 2'b11;
    tick; idle;
    irq_i = 2'b11; boundary_i = 1;
    tick; idle;
    chk("R5 no nesting", level_o, 2);
    tick;
    chk("R5 still level2", level_o, 2);
  endtask

  task automatic t_rti;
    irq_i = 2'b00; rti_i = 1;
    tick; idle;
    chk("R6 return to base", level_o, 3);
    chk("R7 base acc kept", acc_o, 8'h5A);
    chk("R7 base pc kept", pc_o, 16'h1234);
    chk("R7 base link kept", link_o, 1);
    chk("R8 base aux value", aux_o, 0);
    rti_i = 1;
    tick; idle;
    chk("R6 rti at base level", level_o, 3);
    chk("R6 rti at base acc", acc_o, 8'h5A);
  endtask

  task automatic t_priority;
    irq_i = 2'b11; boundary_i = 1;
    tick; idle;
    chk("R4 int1 priority", level_o, 1);
    chk("R7 level1 acc fresh", acc_o, 0);
    rti_i = 1; boundary_i = 1;
    tick; idle;
    chk("R10 rti wins over boundary", level_o, 3);
    rti_i = 1; boundary_i = 1;
    tick; idle;
    chk("R10 rti wins at base", level_o, 3);
    en_we_i = 1; en_wdata_i = 2'b10;
    tick; idle;
    boundary_i = 1;
    tick; idle;
    chk("R9 int1 disabled picks level2", level_o, 2);
    chk("R7 level2 acc kept", acc_o, 8'h77);
    chk("R7 level2 pc kept", pc_o, 16'h0ABC);
    irq_i = 2'b00; rti_i = 1;
    tick; idle;
    chk("R6 final return", level_o, 3);
  endtask

  initial begin
    #(8 * 200000);
    errors++;
    $display("FAIL watchdog actual hung expected done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    @(negedge clk_i);
    t_reset;
    t_base_write;
    t_disabled;
    t_enable_timing;
    t_bank;
    t_no_nest;
    t_rti;
    t_priority;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule